// File: doc/BRIEF.md
# Command RAM Channel Format Parser

This block walks a 64-byte command RAM one byte per clock, starting at offset 0, and turns what it finds into up to five channel descriptors. A descriptor tells a later transaction engine whether a channel takes part, whether it uses the built-in reset command, how long its transmit and receive payloads are, and where in the RAM its length bytes and payloads sit. Four marker byte values steer the walk. One skips a channel. One is padding. One terminates the walk and disables every channel not yet reached. One loads the built-in reset command into the current channel. Any other byte opens a frame made of a transmit-length byte, a receive-length byte and the two payloads.

A pulse on `start_i` begins a scan. The block reads the RAM through a read port that returns data in the same cycle the address is driven. It raises `done_o` for one cycle when the scan ends. `trunc_o` reports a scan that was cut short by a frame starting too close to the end of the RAM. Descriptors that a scan does not reach keep their contents, so one scan can rewrite only the front of the table.

Top module: `cmd_fmt_parser`

## Requirements
- R1: After reset every descriptor is all zero (enable, reset-command flag, lengths and offsets), and `busy_o`, `done_o` and `trunc_o` are low.
- R2: `start_i` while idle begins a scan at byte 0 with channel index 0 and clears `trunc_o`. `busy_o` is high during the scan. `done_o` is high for exactly one cycle as the scan ends, and `busy_o` is low in that cycle. `start_i` during a scan is ignored.
- R3: Byte 0x00 clears the current channel's descriptor to all zero and advances both the channel index and the byte pointer by one.
- R4: Byte 0xFF advances the byte pointer by one and leaves the channel index unchanged; each such byte takes one cycle. For a RAM holding only 0xFF, `done_o` goes high after the 65th rising edge that follows the edge sampling `start_i`.
- R5: Byte 0xFE ends the scan and clears the current channel and every later channel to all zero.
- R6: Byte 0xFD sets the current channel to enable=1, reset-command flag=1, transmit length 1, receive length 3 and all four offsets 0. The built-in command byte is 0xFF. Channel index and byte pointer then advance by one.
- R7: Any other byte at offset p opens a frame: tx = byte[p] & 0x3F and rx = byte[p+1] & 0x3F. The channel is set to enable=1 and flag=0, with transmit-length offset p, receive-length offset p+1, transmit payload offset p+2 and receive payload offset p+2+tx. The pointer advances by 2+tx+rx and the channel index by one.
- R8: A non-marker byte that is directly followed by 0xFE is skipped on its own, and the scan continues at the 0xFE.
- R9: A frame that starts at offset 63, or at offset 62 with byte 63 not 0xFE, ends the scan with `trunc_o` high. The current and later channels keep their contents, and `trunc_o` holds until the next start.
- R10: The scan ends without truncation once the pointer reaches 64 or more, or once five channels have been assigned. Channels not reached keep their previous contents, and descriptors do not change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (sampled while idle) |
| rd_addr_o | output | 6 | RAM byte address |
| rd_data_i | input | 8 | RAM byte at `rd_addr_o`, same cycle |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| trunc_o | output | 1 | Last scan stopped on a truncated frame |
| ch_en_o | output | 5 | Per-channel enable |
| ch_rst_o | output | 5 | Per-channel built-in reset command flag |
| ch_tx_len_o | output | 30 | Per-channel transmit length, 6 bits each, channel 0 lowest |
| ch_rx_len_o | output | 30 | Per-channel receive length, 6 bits each |
| ch_txlen_off_o | output | 40 | Per-channel offset of the transmit-length byte, 8 bits each |
| ch_rxlen_off_o | output | 40 | Per-channel offset of the receive-length byte, 8 bits each |
| ch_tx_off_o | output | 40 | Per-channel offset of the transmit payload, 8 bits each |
| ch_rx_off_o | output | 40 | Per-channel offset of the receive payload, 8 bits each |

## Verification
A wrong byte pointer or channel index shows up in the descriptor table only once `done_o` has pulsed. It appears as a frame decoded at a shifted offset, a channel filled in the wrong slot, or a channel that should have been skipped left intact. The stimuli therefore put marker bytes inside payload regions and pre-load the table with a known pattern. A wrong termination decision shows within the same scan: `done_o` comes at the wrong cycle, `trunc_o` takes the wrong value, or channels that should have been left alone get cleared.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int LEN_W = 6;
  localparam logic [7:0] MK_SKIP = 8'h00;
  localparam logic [7:0] MK_PAD  = 8'hFF;
  localparam logic [7:0] MK_END  = 8'hFE;
  localparam logic [7:0] MK_RST  = 8'hFD;
  localparam int RST_TX = 1;
  localparam int RST_RX = 3;

  typedef enum logic [2:0] {
    BC_SKIP, BC_PAD, BC_END, BC_RST, BC_LEN
  } byte_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SCAN, ST_PEEK
  } scan_st_e;
endpackage

// File: rtl/cfp_byte_class.sv
module cfp_byte_class
  import cfp_pkg::*;
(
  input  logic [7:0]       byte_i,
  output byte_cls_e        cls_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    unique case (byte_i)
      MK_SKIP: cls_o = BC_SKIP;
      MK_PAD:  cls_o = BC_PAD;
      MK_END:  cls_o = BC_END;
      MK_RST:  cls_o = BC_RST;
      default: cls_o = BC_LEN;
    endcase
  end
  assign len_o = byte_i[LEN_W-1:0];
endmodule

// File: rtl/cfp_desc_bank.sv
module cfp_desc_bank #(
  parameter int NCH   = 5,
  parameter int LEN_W = 6,
  parameter int OFF_W = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               clr_i,
  input  logic               clr_up_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wr_rst_i,
  input  logic [LEN_W-1:0]   wr_tx_i,
  input  logic [LEN_W-1:0]   wr_rx_i,
  input  logic [OFF_W-1:0]   wr_base_i,
  output logic [NCH-1:0]       en_o,
  output logic [NCH-1:0]       rst_o,
  output logic [NCH*LEN_W-1:0] tx_o,
  output logic [NCH*LEN_W-1:0] rx_o,
  output logic [NCH*OFF_W-1:0] base_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [IDX_W-1:0] MY = IDX_W'(i);
    logic             en_q, rst_q;
    logic [LEN_W-1:0] tx_q, rx_q;
    logic [OFF_W-1:0] base_q;
    logic             hit_clr, hit_wr;

    assign hit_clr = clr_i && ((idx_i == MY) || (clr_up_i && (MY > idx_i)));
    assign hit_wr  = wr_i && (idx_i == MY);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= 1'b0; rst_q <= 1'b0; tx_q <= '0; rx_q <= '0; base_q <= '0;
      end else if (hit_clr) begin
        en_q <= 1'b0; rst_q <= 1'b0; tx_q <= '0; rx_q <= '0; base_q <= '0;
      end else if (hit_wr) begin
        en_q   <= 1'b1;
        rst_q  <= wr_rst_i;
        tx_q   <= wr_tx_i;
        rx_q   <= wr_rx_i;
        base_q <= wr_base_i;
      end
    end

    assign en_o[i]                 = en_q;
    assign rst_o[i]                = rst_q;
    assign tx_o[i*LEN_W +: LEN_W]  = tx_q;
    assign rx_o[i*LEN_W +: LEN_W]  = rx_q;
    assign base_o[i*OFF_W +: OFF_W] = base_q;
  end
endmodule

// File: rtl/cfp_scan_ctrl.sv
module cfp_scan_ctrl
  import cfp_pkg::*;
#(
  parameter int RAM_BYTES = 64,
  parameter int NCH       = 5,
  parameter int AW        = 6,
  parameter int OFF_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [AW-1:0]      rd_addr_o,
  input  byte_cls_e          cls_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               trunc_o,
  output logic               wr_o,
  output logic               clr_o,
  output logic               clr_up_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               wr_rst_o,
  output logic [LEN_W-1:0]   wr_tx_o,
  output logic [LEN_W-1:0]   wr_rx_o,
  output logic [OFF_W-1:0]   wr_base_o
);
  localparam logic [OFF_W-1:0] PTR_END  = OFF_W'(RAM_BYTES);
  localparam logic [OFF_W-1:0] PTR_LAST = OFF_W'(RAM_BYTES - 1);
  localparam logic [OFF_W-1:0] PTR_PEN  = OFF_W'(RAM_BYTES - 2);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NCH);

  scan_st_e         st_q, st_d;
  logic [OFF_W-1:0] ptr_q, ptr_d, ptr_p1;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] tx_q, tx_d;
  logic             done_q, done_d, trunc_q, trunc_d;

  assign ptr_p1    = ptr_q + OFF_W'(1);
  assign rd_addr_o = (st_q == ST_PEEK) ? ptr_p1[AW-1:0] : ptr_q[AW-1:0];

  always_comb begin
    st_d = st_q; ptr_d = ptr_q; idx_d = idx_q; tx_d = tx_q;
    done_d = 1'b0; trunc_d = trunc_q;
    wr_o = 1'b0; clr_o = 1'b0; clr_up_o = 1'b0; wr_rst_o = 1'b0;
    wr_tx_o = tx_q; wr_rx_o = len_i; wr_base_o = ptr_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_SCAN; ptr_d = '0; idx_d = '0; trunc_d = 1'b0;
      end
      ST_SCAN: begin
        if (ptr_q >= PTR_END || idx_q == IDX_END) begin
          st_d = ST_IDLE; done_d = 1'b1;
        end else begin
          unique case (cls_i)
            BC_SKIP: begin
              clr_o = 1'b1; idx_d = idx_q + 1'b1; ptr_d = ptr_p1;
            end
            BC_PAD: ptr_d = ptr_p1;
            BC_END: begin
              clr_o = 1'b1; clr_up_o = 1'b1; st_d = ST_IDLE; done_d = 1'b1;
            end
            BC_RST: begin
              wr_o = 1'b1; wr_rst_o = 1'b1;
              wr_tx_o = LEN_W'(RST_TX); wr_rx_o = LEN_W'(RST_RX); wr_base_o = '0;
              idx_d = idx_q + 1'b1; ptr_d = ptr_p1;
            end
            default: begin
              if (ptr_q == PTR_LAST) begin
                trunc_d = 1'b1; st_d = ST_IDLE; done_d = 1'b1;
              end else begin
                tx_d = len_i; st_d = ST_PEEK;
              end
            end
          endcase
        end
      end
      ST_PEEK: begin
        if (cls_i == BC_END) begin
          // lone byte ahead of an end marker is dropped
          ptr_d = ptr_p1; st_d = ST_SCAN;
        end else if (ptr_q >= PTR_PEN) begin
          trunc_d = 1'b1; st_d = ST_IDLE; done_d = 1'b1;
        end else begin
          wr_o  = 1'b1;
          ptr_d = ptr_q + OFF_W'(2) + OFF_W'(tx_q) + OFF_W'(len_i);
          idx_d = idx_q + 1'b1; st_d = ST_SCAN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ptr_q <= '0; idx_q <= '0; tx_q <= '0;
      done_q <= 1'b0; trunc_q <= 1'b0;
    end else begin
      st_q <= st_d; ptr_q <= ptr_d; idx_q <= idx_d; tx_q <= tx_d;
      done_q <= done_d; trunc_q <= trunc_d;
    end
  end

  assign idx_o   = idx_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign trunc_o = trunc_q;
endmodule

// File: rtl/cmd_fmt_parser.sv
module cmd_fmt_parser
  import cfp_pkg::*;
#(
  parameter int RAM_BYTES = 64,
  parameter int NCH       = 5,
  localparam int AW    = $clog2(RAM_BYTES),
  localparam int OFF_W = AW + 2,
  localparam int IDX_W = $clog2(NCH + 1),
  localparam int LW    = LEN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [AW-1:0]       rd_addr_o,
  input  logic [7:0]          rd_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                trunc_o,
  output logic [NCH-1:0]      ch_en_o,
  output logic [NCH-1:0]      ch_rst_o,
  output logic [NCH*LW-1:0]   ch_tx_len_o,
  output logic [NCH*LW-1:0]   ch_rx_len_o,
  output logic [NCH*OFF_W-1:0] ch_txlen_off_o,
  output logic [NCH*OFF_W-1:0] ch_rxlen_off_o,
  output logic [NCH*OFF_W-1:0] ch_tx_off_o,
  output logic [NCH*OFF_W-1:0] ch_rx_off_o
);
  byte_cls_e        cls;
  logic [LW-1:0]    len;
  logic             wr, clr, clr_up, wr_rst;
  logic [IDX_W-1:0] idx;
  logic [LW-1:0]    wr_tx, wr_rx;
  logic [OFF_W-1:0] wr_base;
  logic [NCH*OFF_W-1:0] base;

  cfp_byte_class u_cls (.byte_i(rd_data_i), .cls_o(cls), .len_o(len));

  cfp_scan_ctrl #(
    .RAM_BYTES(RAM_BYTES), .NCH(NCH), .AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .rd_addr_o,
    .cls_i(cls), .len_i(len),
    .busy_o, .done_o, .trunc_o,
    .wr_o(wr), .clr_o(clr), .clr_up_o(clr_up), .idx_o(idx),
    .wr_rst_o(wr_rst), .wr_tx_o(wr_tx), .wr_rx_o(wr_rx), .wr_base_o(wr_base)
  );

  cfp_desc_bank #(
    .NCH(NCH), .LEN_W(LW), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk_i, .rst_ni,
    .wr_i(wr), .clr_i(clr), .clr_up_i(clr_up), .idx_i(idx),
    .wr_rst_i(wr_rst), .wr_tx_i(wr_tx), .wr_rx_i(wr_rx), .wr_base_i(wr_base),
    .en_o(ch_en_o), .rst_o(ch_rst_o), .tx_o(ch_tx_len_o), .rx_o(ch_rx_len_o),
    .base_o(base)
  );

  // offsets derived from base; zero for idle and canned-command channels
  for (genvar i = 0; i < NCH; i++) begin : g_off
    logic             live;
    logic [OFF_W-1:0] b;
    assign live = ch_en_o[i] && !ch_rst_o[i];
    assign b    = base[i*OFF_W +: OFF_W];
    assign ch_txlen_off_o[i*OFF_W +: OFF_W] = live ? b : '0;
    assign ch_rxlen_off_o[i*OFF_W +: OFF_W] = live ? b + OFF_W'(1) : '0;
    assign ch_tx_off_o[i*OFF_W +: OFF_W]    = live ? b + OFF_W'(2) : '0;
    assign ch_rx_off_o[i*OFF_W +: OFF_W]    =
      live ? b + OFF_W'(2) + OFF_W'(ch_tx_len_o[i*LW +: LW]) : '0;
  end
endmodule

// File: rtl/cmd_fmt_parser_chk.sv
module cmd_fmt_parser_chk #(
  parameter int NCH = 5,
  parameter int LW  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              trunc_o,
  input logic [NCH-1:0]    ch_en_o,
  input logic [NCH-1:0]    ch_rst_o,
  input logic [NCH*LW-1:0] ch_tx_len_o,
  input logic [NCH*LW-1:0] ch_rx_len_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ch_en_o) && $stable(ch_rst_o)
      && $stable(ch_tx_len_o) && $stable(ch_rx_len_o))); // R10
  AST_TRUNC_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trunc_o) |-> done_o); // R9
  for (genvar i = 0; i < NCH; i++) begin : g_rst
    AST_RST_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_rst_o[i] |-> (ch_en_o[i] && ch_tx_len_o[i*LW +: LW] == LW'(1)
        && ch_rx_len_o[i*LW +: LW] == LW'(3))); // R6
  end
endmodule

bind cmd_fmt_parser cmd_fmt_parser_chk #(.NCH(NCH), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .trunc_o(trunc_o), .ch_en_o(ch_en_o), .ch_rst_o(ch_rst_o),
  .ch_tx_len_o(ch_tx_len_o), .ch_rx_len_o(ch_rx_len_o)
);

// File: tb/cmd_fmt_parser_tb.sv
`timescale 1ns/1ps
module cmd_fmt_parser_tb;
  localparam int NCH = 5;
  localparam int LW  = 6;
  localparam int OW  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] rd_addr;
  logic [7:0] mem [64];
  logic busy, done, trunc;
  logic [NCH-1:0] en, rs;
  logic [NCH*LW-1:0] txl, rxl;
  logic [NCH*OW-1:0] txlo, rxlo, txo, rxo;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmd_fmt_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_addr_o(rd_addr),
    .rd_data_i(mem[rd_addr]), .busy_o(busy), .done_o(done), .trunc_o(trunc),
    .ch_en_o(en), .ch_rst_o(rs), .ch_tx_len_o(txl), .ch_rx_len_o(rxl),
    .ch_txlen_off_o(txlo), .ch_rxlen_off_o(rxlo), .ch_tx_off_o(txo), .ch_rx_off_o(rxo)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ch(input string req, input int i, input int e, input int r,
                        input int t, input int x, input int b);
    int o1, o2, o3, o4;
    chk({req, " en"}, int'(en[i]), e);
    chk({req, " rst"}, int'(rs[i]), r);
    chk({req, " tx"}, int'(txl[i*LW +: LW]), t);
    chk({req, " rx"}, int'(rxl[i*LW +: LW]), x);
    if (e == 1 && r == 0) begin o1 = b; o2 = b + 1; o3 = b + 2; o4 = b + 2 + t; end
    else begin o1 = 0; o2 = 0; o3 = 0; o4 = 0; end
    chk({req, " txl_off"}, int'(txlo[i*OW +: OW]), o1);
    chk({req, " rxl_off"}, int'(rxlo[i*OW +: OW]), o2);
    chk({req, " tx_off"}, int'(txo[i*OW +: OW]), o3);
    chk({req, " rx_off"}, int'(rxo[i*OW +: OW]), o4);
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 64; i++) mem[i] = v;
  endtask

  task automatic run_scan;
    bit seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 1000 && !seen; k++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk("R2 done seen", int'(seen), 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 trunc", int'(trunc), 0);
    for (int i = 0; i < NCH; i++) chk_ch("R1 ch", i, 0, 0, 0, 0, 0);
  endtask

  task automatic t_full;
    fill(8'h00);
    for (int i = 0; i < NCH; i++) begin mem[2*i] = 8'h40; mem[2*i+1] = 8'h80; end
    mem[10] = 8'hFE;
    run_scan();
    chk("R2 trunc cleared", int'(trunc), 0);
    for (int i = 0; i < NCH; i++) chk_ch("R10 R7 full", i, 1, 0, 0, 0, 2*i);
  endtask

  task automatic t_markers;
    fill(8'hFF);
    mem[0] = 8'h01; mem[1] = 8'h04;
    for (int i = 2; i < 7; i++) mem[i] = 8'h00;
    mem[7] = 8'hFF; mem[8] = 8'h00; mem[9] = 8'hFD;
    mem[10] = 8'hC2; mem[11] = 8'h41;
    for (int i = 12; i < 15; i++) mem[i] = 8'h00;
    mem[15] = 8'hFE;
    run_scan();
    chk_ch("R7 frame ch0", 0, 1, 0, 1, 4, 0);
    chk_ch("R3 skip ch1", 1, 0, 0, 0, 0, 0);
    chk_ch("R6 reset ch2", 2, 1, 1, 1, 3, 0);
    chk_ch("R7 R4 masked ch3", 3, 1, 0, 2, 1, 10);
    chk_ch("R5 end ch4", 4, 0, 0, 0, 0, 0);
    chk("R5 trunc", int'(trunc), 0);
  endtask

  task automatic t_bogus;
    fill(8'h00);
    mem[0] = 8'h07; mem[1] = 8'hFE; mem[2] = 8'h01; mem[3] = 8'h01;
    run_scan();
    for (int i = 0; i < NCH; i++) chk_ch("R8 bogus", i, 0, 0, 0, 0, 0);
  endtask

  task automatic t_trunc;
    fill(8'hFF); mem[62] = 8'h02; mem[63] = 8'h01;
    run_scan();
    chk("R9 trunc at 62", int'(trunc), 1);
    for (int i = 0; i < NCH; i++) chk_ch("R9 kept", i, 1, 0, 0, 0, 2*i);
    repeat (3) @(negedge clk);
    chk("R9 trunc holds", int'(trunc), 1);
    fill(8'hFF); mem[63] = 8'h05;
    run_scan();
    chk("R9 trunc at 63", int'(trunc), 1);
    chk_ch("R9 kept ch0", 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_edge_fe;
    fill(8'hFF); mem[62] = 8'h05; mem[63] = 8'hFE;
    run_scan();
    chk("R8 no trunc at 62", int'(trunc), 0);
    for (int i = 0; i < NCH; i++) chk_ch("R8 R5 edge", i, 0, 0, 0, 0, 0);
  endtask

  task automatic t_runout;
    fill(8'hFF); mem[0] = 8'h3F; mem[1] = 8'hBF;
    run_scan();
    chk("R10 trunc", int'(trunc), 0);
    chk_ch("R7 R10 big frame", 0, 1, 0, 63, 63, 0);
    for (int i = 1; i < NCH; i++) chk_ch("R10 unreached", i, 1, 0, 0, 0, 2*i);
  endtask

  task automatic t_pad_timing;
    int at = -1, pulses = 0;
    fill(8'hFF);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      if (k == 10) start = 1'b1;
      if (k == 11) start = 1'b0;
      if (done) begin pulses++; if (at < 0) at = k; end
    end
    chk("R4 pad scan cycles", at, 65);
    chk("R2 restart ignored", pulses, 1);
    for (int i = 0; i < NCH; i++) chk_ch("R4 pad keeps", i, 1, 0, 0, 0, 2*i);
  endtask

  initial begin
    #1_200_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    fill(8'hFF);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full();
    t_markers();
    t_bogus();
    t_full();
    t_trunc();
    t_full();
    t_edge_fe();
    t_full();
    t_runout();
    t_full();
    t_pad_timing();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule